// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Condition Flags

This unit performs integer addition and subtraction on two operands at either 32-bit or 64-bit width. The width is chosen for each operation. It keeps a four-bit flag register holding negative, zero, carry and overflow. Plain add and subtract ignore the stored carry. The carry-chaining forms use the stored carry as their carry-in, so wide arithmetic can be split across several operations. Every subtraction is formed as the first operand plus the bitwise inverse of the second operand plus a carry-in. A plain subtract uses a carry-in of one.

Two compare operations only touch the flags. The positive compare subtracts and the negative compare adds. Each compare carries a four-bit condition code, which the unit evaluates against its current flags. When the condition holds, the flags take the outcome of the compare. When the condition does not hold, the flags are loaded from a four-bit immediate that comes with the operation. Arithmetic operations update the flags only when their set-flags input is high.

Operations enter through a valid/ready port and leave through a one-entry registered valid/ready output. The result and the flag write take effect on the same clock edge, the edge on which the operation is accepted. An operation is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new operation is taken. The producer must keep its inputs stable until the operation is accepted. The flag register is visible at all times on `flags`.

Top module: `arith_flag_unit`

## Requirements
- R1: After reset, `flags` is 0000, `out_valid` is 0 and `in_ready` is 1.
- R2: Operation codes are 0 add, 1 subtract, 2 add-with-carry, 3 subtract-with-carry, 4 conditional compare, 5 conditional compare-negative; codes 6 and 7 act as add. Add gives a+b; subtract gives a+~b+1.
- R3: Add-with-carry gives a+b+C and subtract-with-carry gives a+~b+C, where C is the stored carry flag at the time the operation is accepted, including a carry written by the operation accepted one cycle earlier.
- R4: The C flag is 1 exactly when the unsigned sum of the two adder inputs and the carry-in exceeds the largest unsigned value of the active width.
- R5: The V flag is 1 exactly when both adder inputs have the same sign bit and the result's sign bit differs from it.
- R6: The `flags` nibble is ordered {N,Z,C,V} from bit 3 down to bit 0. N is the top bit of the result at the active width, and Z is 1 when the result at that width is all zeros.
- R7: With `in_wide`=0, only bits 31:0 of the operands take part in the result and the flags, and `out_result` bits 63:32 are zero.
- R8: An arithmetic operation (codes 0–3, 6, 7) accepted with `in_set_flags`=0 leaves `flags` unchanged.
- R9: A compare whose condition holds writes the flags of a−b (code 4) or a+b (code 5), whatever the value of `in_set_flags`, and outputs a result of zero.
- R10: A compare whose condition fails loads `flags` from `in_nzcv_imm`, and outputs a result of zero.
- R11: Condition codes, evaluated on the stored flags: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !(C&!Z), 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 !(!Z&(N==V)); codes 14 and 15 always hold.
- R12: `in_ready` = !`out_valid` | `out_ready`. While `out_valid` is high and `out_ready` is low, `out_result` and `out_valid` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit |
| in_op | input | 3 | Operation code |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| in_set_flags | input | 1 | Arithmetic operation writes the flags |
| in_cond | input | 4 | Condition code for the compares |
| in_nzcv_imm | input | 4 | Flags loaded when a compare's condition fails |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Result, zero-extended in 32-bit mode |
| flags | output | 4 | Stored flags {N,Z,C,V} |

## Verification
Two events can share one clock edge. The consumer can drain the held result on the same edge that the next operation is accepted and writes the flags. That next operation can also be a carry-consuming operation that reads the carry written one edge earlier. The first case is provoked by holding `out_ready` low while an operation waits, then raising it. The bench checks that the stalled result never changes, that the waiting operation is taken on exactly the release edge, and that its result follows directly. The second case is provoked by issuing a flag-setting add and an add-with-carry back to back, with no idle cycle between them. The bench judges the second sum against a reference that holds the carry produced by the first operation.

// File: rtl/afu_pkg.sv
package afu_pkg;

  localparam logic [2:0] OPC_ADD  = 3'd0;
  localparam logic [2:0] OPC_SUB  = 3'd1;
  localparam logic [2:0] OPC_ADDC = 3'd2;
  localparam logic [2:0] OPC_SUBC = 3'd3;
  localparam logic [2:0] OPC_CMPP = 3'd4;
  localparam logic [2:0] OPC_CMPN = 3'd5;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

endpackage

// File: rtl/afu_lanes.sv
module afu_lanes import afu_pkg::*; #(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic [WIDE_W-1:0] a_i,
  input  logic [WIDE_W-1:0] b_i,
  input  logic              inv_b_i,
  input  logic              cin_i,
  input  logic              wide_i,
  output logic [WIDE_W-1:0] res_o,
  output nzcv_t             nzcv_o
);

  localparam int LANES = 2;

  logic [WIDE_W-1:0] lane_res  [LANES];
  nzcv_t             lane_nzcv [LANES];

  // Lane 0 works at the narrow width, lane 1 at the wide width.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? NARROW_W : WIDE_W;
    logic [LW-1:0] opa;
    logic [LW-1:0] opb;
    logic [LW:0]   sum;

    assign opa = a_i[LW-1:0];
    assign opb = b_i[LW-1:0] ^ {LW{inv_b_i}};
    assign sum = {1'b0, opa} + {1'b0, opb} + {{LW{1'b0}}, cin_i};

    if (LW == WIDE_W) begin : g_full
      assign lane_res[g] = sum[LW-1:0];
    end else begin : g_zext
      assign lane_res[g] = {{(WIDE_W-LW){1'b0}}, sum[LW-1:0]};
    end

    assign lane_nzcv[g].n = sum[LW-1];
    assign lane_nzcv[g].z = (sum[LW-1:0] == '0);
    assign lane_nzcv[g].c = sum[LW];
    assign lane_nzcv[g].v = (opa[LW-1] == opb[LW-1]) && (sum[LW-1] != opa[LW-1]);
  end

  assign res_o  = wide_i ? lane_res[1]  : lane_res[0];
  assign nzcv_o = wide_i ? lane_nzcv[1] : lane_nzcv[0];

endmodule

// File: rtl/afu_cond.sv
module afu_cond import afu_pkg::*; (
  input  logic [3:0] cond_i,
  input  nzcv_t      fl_i,
  output logic       pass_o
);

  logic ge;
  logic hi;
  logic gt;

  assign ge = (fl_i.n == fl_i.v);
  assign hi = fl_i.c & ~fl_i.z;
  assign gt = ~fl_i.z & ge;

  always_comb begin
    case (cond_i)
      4'd0:    pass_o = fl_i.z;
      4'd1:    pass_o = ~fl_i.z;
      4'd2:    pass_o = fl_i.c;
      4'd3:    pass_o = ~fl_i.c;
      4'd4:    pass_o = fl_i.n;
      4'd5:    pass_o = ~fl_i.n;
      4'd6:    pass_o = fl_i.v;
      4'd7:    pass_o = ~fl_i.v;
      4'd8:    pass_o = hi;
      4'd9:    pass_o = ~hi;
      4'd10:   pass_o = ge;
      4'd11:   pass_o = ~ge;
      4'd12:   pass_o = gt;
      4'd13:   pass_o = ~gt;
      default: pass_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit import afu_pkg::*; #(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_wide,
  input  logic [2:0]        in_op,
  input  logic [WIDE_W-1:0] in_a,
  input  logic [WIDE_W-1:0] in_b,
  input  logic              in_set_flags,
  input  logic [3:0]        in_cond,
  input  logic [3:0]        in_nzcv_imm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WIDE_W-1:0] out_result,
  output logic [3:0]        flags
);

  nzcv_t             flags_q;
  nzcv_t             calc;
  logic [WIDE_W-1:0] sum_res;
  logic              is_cmp;
  logic              inv_b;
  logic              cin;
  logic              cond_ok;
  logic              accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign flags    = flags_q;

  // Operation decode: subtract forms invert b; carry-in from code or stored C.
  always_comb begin
    is_cmp = 1'b0;
    inv_b  = 1'b0;
    cin    = 1'b0;
    case (in_op)
      OPC_SUB:  begin inv_b = 1'b1; cin = 1'b1; end
      OPC_ADDC: cin = flags_q.c;
      OPC_SUBC: begin inv_b = 1'b1; cin = flags_q.c; end
      OPC_CMPP: begin is_cmp = 1'b1; inv_b = 1'b1; cin = 1'b1; end
      OPC_CMPN: is_cmp = 1'b1;
      default:  ;
    endcase
  end

  afu_lanes #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) i_lanes (
    .a_i     (in_a),
    .b_i     (in_b),
    .inv_b_i (inv_b),
    .cin_i   (cin),
    .wide_i  (in_wide),
    .res_o   (sum_res),
    .nzcv_o  (calc)
  );

  afu_cond i_cond (
    .cond_i (in_cond),
    .fl_i   (flags_q),
    .pass_o (cond_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      flags_q    <= '0;
    end else begin
      if (accept) begin
        out_valid  <= 1'b1;
        out_result <= is_cmp ? '0 : sum_res;
        if (is_cmp) begin
          flags_q <= cond_ok ? calc : nzcv_t'(in_nzcv_imm);
        end else if (in_set_flags) begin
          flags_q <= calc;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !is_cmp && !in_set_flags |=> flags == $past(flags)); // R8

  AST_CMP_FAIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    accept && is_cmp && !cond_ok |=> flags == $past(in_nzcv_imm)); // R10

  AST_CMP_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && is_cmp |=> out_result == '0); // R9

  AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_wide |=> out_result[WIDE_W-1:NARROW_W] == '0); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)); // R12

endmodule

// File: tb/test_arith_flag_unit.sv
module test_arith_flag_unit;

  localparam logic [2:0] K_ADD = 3'd0, K_SUB = 3'd1, K_ADC = 3'd2, K_SBC = 3'd3,
                         K_CMP = 3'd4, K_CMN = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_wide = 1'b1;
  logic [2:0]  in_op = '0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        in_set_flags = 1'b0;
  logic [3:0]  in_cond = '0;
  logic [3:0]  in_nzcv_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic [3:0]  flags;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [3:0] exp_flags = 4'b0000;

  always #2.5 clk = ~clk;

  arith_flag_unit i_arith_flag_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_wide(in_wide), .in_op(in_op), .in_a(in_a), .in_b(in_b),
    .in_set_flags(in_set_flags), .in_cond(in_cond), .in_nzcv_imm(in_nzcv_imm),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .flags(flags)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++;
      total++;
      $display("FAIL watchdog R12 got=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic cond_true(logic [3:0] c, logic [3:0] f);
    logic n, z, cc, v, r;
    n = f[3]; z = f[2]; cc = f[1]; v = f[0];
    case (c[3:1])
      3'd0: r = z;
      3'd1: r = cc;
      3'd2: r = n;
      3'd3: r = v;
      3'd4: r = cc && !z;
      3'd5: r = (n == v);
      3'd6: r = !z && (n == v);
      default: r = 1'b1;
    endcase
    if (c[0] && c[3:1] != 3'd7) r = !r;
    return r;
  endfunction

  function automatic void model(input logic w, input logic [2:0] op,
                                input logic [63:0] a, input logic [63:0] b,
                                input logic sf, input logic [3:0] cnd,
                                input logic [3:0] imm, input logic [3:0] fin,
                                output logic [63:0] r, output logic [3:0] f);
    logic inv, ci, cmp, n, z, c, v;
    logic [63:0] bb, rr;
    logic [64:0] us;
    logic [66:0] ss;
    logic [32:0] us32;
    logic [34:0] ss32;
    inv = (op == K_SUB) || (op == K_SBC) || (op == K_CMP);
    cmp = (op == K_CMP) || (op == K_CMN);
    if (op == K_SUB || op == K_CMP) ci = 1'b1;
    else if (op == K_ADC || op == K_SBC) ci = fin[1];
    else ci = 1'b0;
    bb = inv ? ~b : b;
    if (w) begin
      us = {1'b0, a} + {1'b0, bb} + {64'b0, ci};
      rr = us[63:0];
      c  = us[64];
      ss = {{3{a[63]}}, a} + {{3{bb[63]}}, bb} + {66'b0, ci};
      v  = (ss != {{3{rr[63]}}, rr});
      n  = rr[63];
      z  = (rr == 64'd0);
    end else begin
      us32 = {1'b0, a[31:0]} + {1'b0, bb[31:0]} + {32'b0, ci};
      rr   = {32'b0, us32[31:0]};
      c    = us32[32];
      ss32 = {{3{a[31]}}, a[31:0]} + {{3{bb[31]}}, bb[31:0]} + {34'b0, ci};
      v    = (ss32 != {{3{rr[31]}}, rr[31:0]});
      n    = rr[31];
      z    = (rr[31:0] == 32'd0);
    end
    if (cmp) begin
      r = 64'd0;
      f = cond_true(cnd, fin) ? {n, z, c, v} : imm;
    end else begin
      r = rr;
      f = sf ? {n, z, c, v} : fin;
    end
  endfunction

  task automatic put(logic w, logic [2:0] op, logic [63:0] a, logic [63:0] b,
                     logic sf, logic [3:0] cnd, logic [3:0] imm);
    in_wide = w; in_op = op; in_a = a; in_b = b;
    in_set_flags = sf; in_cond = cnd; in_nzcv_imm = imm;
    in_valid = 1'b1;
  endtask

  // One operation with out_ready high; checks result and flags.
  task automatic run_op(string tag, logic w, logic [2:0] op, logic [63:0] a,
                        logic [63:0] b, logic sf, logic [3:0] cnd, logic [3:0] imm);
    logic [63:0] er;
    logic [3:0]  ef;
    model(w, op, a, b, sf, cnd, imm, exp_flags, er, ef);
    @(negedge clk);
    put(w, op, a, b, sf, cnd, imm);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    exp_flags = ef;
    check({tag, " result"}, out_result, er);
    check({tag, " flags"}, {60'b0, flags}, {60'b0, ef});
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 out_valid", {63'b0, out_valid}, 64'd0);
    check("R1 flags", {60'b0, flags}, 64'd0);
    check("R1 in_ready", {63'b0, in_ready}, 64'd1);
  endtask

  task automatic t_add_sub;
    run_op("R2 add", 1, K_ADD, 64'd5, 64'd7, 1, 0, 0);
    run_op("R2 R6 sub zero", 1, K_SUB, 64'd5, 64'd5, 1, 0, 0);
    run_op("R6 sub neg", 1, K_SUB, 64'd3, 64'd5, 1, 0, 0);
    run_op("R4 add wrap", 1, K_ADD, {64{1'b1}}, 64'd1, 1, 0, 0);
    run_op("R5 add ovf", 1, K_ADD, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1, 0, 0);
    run_op("R5 sub ovf", 1, K_SUB, 64'h8000_0000_0000_0000, 64'd1, 1, 0, 0);
    run_op("R2 code6 add", 1, 3'd6, 64'd100, 64'd23, 1, 0, 0);
  endtask

  task automatic t_narrow;
    run_op("R7 ovf", 0, K_ADD, 64'hDEAD_BEEF_7FFF_FFFF, 64'h1234_5678_0000_0001, 1, 0, 0);
    run_op("R7 sub zero", 0, K_SUB, 64'hFFFF_FFFF_0000_0000, 64'd0, 1, 0, 0);
    run_op("R7 carry", 0, K_ADD, 64'h0000_0001_FFFF_FFFF, 64'd1, 1, 0, 0);
  endtask

  task automatic t_carry;
    run_op("R3 set C", 1, K_ADD, {64{1'b1}}, 64'd1, 1, 0, 0);
    run_op("R3 adc", 1, K_ADC, 64'd10, 64'd20, 1, 0, 0);
    run_op("R3 clr C", 1, K_SUB, 64'd0, 64'd1, 1, 0, 0);
    run_op("R3 sbc", 1, K_SBC, 64'd10, 64'd3, 1, 0, 0);
  endtask

  // ADDS then ADC accepted on consecutive edges.
  task automatic t_back_to_back;
    logic [63:0] r1, r2;
    logic [3:0]  f1, f2;
    model(1, K_ADD, {64{1'b1}}, 64'd2, 1, 0, 0, exp_flags, r1, f1);
    model(0, K_ADC, 64'd40, 64'd1, 1, 0, 0, f1, r2, f2);
    @(negedge clk);
    put(1, K_ADD, {64{1'b1}}, 64'd2, 1, 0, 0);
    @(posedge clk);
    @(negedge clk);
    check("R3 b2b first", out_result, r1);
    put(0, K_ADC, 64'd40, 64'd1, 1, 0, 0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 b2b adc", out_result, r2);
    check("R3 b2b flags", {60'b0, flags}, {60'b0, f2});
    exp_flags = f2;
  endtask

  task automatic t_noflags;
    run_op("R8 preset", 1, K_SUB, 64'd3, 64'd5, 1, 0, 0);
    run_op("R8 add nf", 1, K_ADD, {64{1'b1}}, 64'd1, 0, 0, 0);
    run_op("R8 sub nf", 0, K_SUB, 64'd9, 64'd9, 0, 0, 0);
    run_op("R8 adc nf", 1, K_ADC, 64'd1, 64'd1, 0, 0, 0);
  endtask

  task automatic t_ccmp;
    run_op("R9 preset Z", 1, K_SUB, 64'd5, 64'd5, 1, 0, 0);
    run_op("R9 cmp pass eq", 1, K_CMP, 64'd1, 64'd2, 0, 4'd0, 4'b0101);
    run_op("R9 cmp pass ne", 0, K_CMP, 64'd7, 64'd7, 1, 4'd1, 4'b0001);
    run_op("R10 cmp fail", 1, K_CMP, 64'd7, 64'd7, 1, 4'd1, 4'b1010);
    run_op("R10 cmn fail", 1, K_CMN, 64'd7, 64'd7, 1, 4'd3, 4'b0111);
    run_op("R9 cmn pass al", 1, K_CMN, {64{1'b1}}, 64'd1, 0, 4'd14, 4'b1000);
  endtask

  task automatic t_cond_codes;
    logic [63:0] pa [5];
    logic [63:0] pb [5];
    logic [2:0]  po [5];
    pa[0] = 64'd3;                   pb[0] = 64'd5; po[0] = K_SUB;
    pa[1] = 64'd5;                   pb[1] = 64'd5; po[1] = K_SUB;
    pa[2] = 64'h7FFF_FFFF_FFFF_FFFF; pb[2] = 64'd1; po[2] = K_ADD;
    pa[3] = 64'h8000_0000_0000_0000; pb[3] = 64'd1; po[3] = K_SUB;
    pa[4] = 64'd5;                   pb[4] = 64'd3; po[4] = K_SUB;
    for (int p = 0; p < 5; p++) begin
      for (int c = 0; c < 16; c++) begin
        run_op("R11 preset", 1, po[p], pa[p], pb[p], 1, 0, 0);
        run_op("R11 cond", 1, K_CMP, 64'd0, 64'd0, 0, 4'(c), 4'b1001);
      end
    end
  endtask

  task automatic t_backpressure;
    logic [63:0] r1, r2;
    logic [3:0]  f1, f2;
    model(1, K_ADD, 64'd11, 64'd22, 1, 0, 0, exp_flags, r1, f1);
    model(1, K_SUB, 64'd50, 64'd8, 1, 0, 0, f1, r2, f2);
    @(negedge clk);
    out_ready = 1'b0;
    put(1, K_ADD, 64'd11, 64'd22, 1, 0, 0);
    @(posedge clk);
    @(negedge clk);
    put(1, K_SUB, 64'd50, 64'd8, 1, 0, 0);
    check("R12 ready low", {63'b0, in_ready}, 64'd0);
    check("R12 held 1", out_result, r1);
    @(posedge clk);
    @(negedge clk);
    check("R12 held 2", out_result, r1);
    check("R12 still valid", {63'b0, out_valid}, 64'd1);
    check("R12 flags not taken", {60'b0, flags}, {60'b0, f1});
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R12 next result", out_result, r2);
    check("R12 next flags", {60'b0, flags}, {60'b0, f2});
    exp_flags = f2;
    @(posedge clk);
    @(negedge clk);
    check("R12 drained", {63'b0, out_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_add_sub();
    t_narrow();
    t_carry();
    t_back_to_back();
    t_noflags();
    t_ccmp();
    t_cond_codes();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule